// File: doc/BRIEF.md
# Dual-Channel IDE I/O Window Decoder

This block sits between a host I/O bus and a two-channel IDE controller. Five base registers set where its address windows lie. Each channel has a command window and a control window, and the two channels share one bus-master window. On every access the block compares the address against all five windows and picks one by fixed priority. It then forwards the strobe, size and data to that channel's register port with a translated local offset, or to the bus-master register port. The read data comes back on the same cycle.

The control-window registers live in the same offset space as the command registers, shifted up by a fixed amount. Channel logic therefore sees one flat 5-bit register space. An access that matches nothing is not claimed. A read that matches nothing returns all ones, and a write that matches nothing reaches no port. A sizing mask for each base index is provided so that the host can find each window's size.

Top module: `ide_io_decoder`

## Requirements
- R1: After reset every base register reads as zero on `base_rdata`.
- R2: A load with `base_ld` high and `base_idx` 0 to 4 stores `base_wdata` with bits [1:0] cleared, visible from the next cycle. Index 0 is the channel 0 command window, 1 the channel 0 control window, 2 the channel 1 command window, 3 the channel 1 control window and 4 the bus-master window. A load to index 5, 6 or 7 changes no base, and those indices read back as zero.
- R3: `base_mask` reports 0xFFFFFFF9 for indices 0 and 2, 0xFFFFFFFD for indices 1 and 3, 0xFFFFFFF1 for index 4 and zero for indices 5 to 7.
- R4: An access hits a command window when the address with bits [2:0] cleared equals that base. The channel then receives the strobe, `io_size` and `io_wdata` unchanged, with offset = address[2:0].
- R5: An access hits a control window when the address with bits [1:0] cleared equals that base. The channel offset is then address[1:0] + 0x14.
- R6: An access hits the bus-master window when the address with bits [3:0] cleared equals its base. The bus-master port then gets offset = address[3:0] and write data = `io_wdata`[7:0], and its 8-bit read data comes back zero-extended.
- R7: When windows overlap, the winner is decided in this order: channel 0 command, channel 1 command, channel 0 control, channel 1 control, bus master.
- R8: An access that hits no window leaves `io_hit` low and raises no port strobe. A read that hits no window returns 0xFFFFFFFF on `io_rdata`.
- R9: `io_hit` is high exactly when `io_rd` or `io_wr` is high and some window matches. At most one target port is strobed, and the read data comes from that target in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ld | input | 1 | Load strobe for a base register |
| base_idx | input | 3 | Base register index for load, readback and mask |
| base_wdata | input | 32 | Value to load |
| base_rdata | output | 32 | Stored base at `base_idx` |
| base_mask | output | 32 | Writable-bit sizing mask for `base_idx` |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_addr | input | 32 | Host I/O address |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data |
| io_hit | output | 1 | Access claimed |
| ch0_rd | output | 1 | Channel 0 read strobe |
| ch0_wr | output | 1 | Channel 0 write strobe |
| ch0_ofs | output | 5 | Channel 0 register offset |
| ch0_size | output | 3 | Channel 0 access size |
| ch0_wdata | output | 32 | Channel 0 write data |
| ch0_rdata | input | 32 | Channel 0 read data |
| ch1_rd | output | 1 | Channel 1 read strobe |
| ch1_wr | output | 1 | Channel 1 write strobe |
| ch1_ofs | output | 5 | Channel 1 register offset |
| ch1_size | output | 3 | Channel 1 access size |
| ch1_wdata | output | 32 | Channel 1 write data |
| ch1_rdata | input | 32 | Channel 1 read data |
| bm_rd | output | 1 | Bus-master register read strobe |
| bm_wr | output | 1 | Bus-master register write strobe |
| bm_ofs | output | 4 | Bus-master register offset |
| bm_wdata | output | 8 | Bus-master write byte |
| bm_rdata | input | 8 | Bus-master read byte |

## Verification
The embedded assertions check, on every cycle, the rules that do not depend on where the windows lie. Stored bases always have bits [1:0] clear, and a load to an unused index leaves the bases untouched. No more than one port is strobed. A miss is silent and reads as all ones. Each offset falls in its window's range. What only the bench's scenarios can show is that the windows sit at the right addresses with the right sizes. That covers the first and last byte of each window and the byte just outside it, the priority between overlapping windows, and the exact translated offsets and data routing. The bench checks these against its own model of the base registers over directed and random address patterns.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int unsigned AW   = 32;
  localparam int unsigned DW   = 32;
  localparam int unsigned NWIN = 5;
  localparam int unsigned IDXW = 3;
  localparam int unsigned OFSW = 5;

  typedef enum logic [IDXW-1:0] {
    WIN_C0_CMD = 3'd0,
    WIN_C0_CTL = 3'd1,
    WIN_C1_CMD = 3'd2,
    WIN_C1_CTL = 3'd3,
    WIN_BM     = 3'd4
  } win_e;

  // log2 of each window's byte span
  function automatic int unsigned win_lg(input int unsigned i);
    case (i)
      0, 2:    return 3;
      1, 3:    return 2;
      default: return 4;
    endcase
  endfunction

  // sizing mask: address bits above the span writable, bit 0 set as I/O flag
  function automatic logic [AW-1:0] win_mask(input int unsigned i);
    logic [AW-1:0] low;
    low = {AW{1'b1}} >> (AW - win_lg(i));
    return ~low | {{(AW-1){1'b0}}, 1'b1};
  endfunction

  // local channel offset: control registers shifted up by ctl_add
  function automatic logic [OFSW-1:0] chan_ofs(input logic [AW-1:0] addr,
                                               input logic is_ctl,
                                               input logic [OFSW-1:0] ctl_add);
    if (is_ctl) return ctl_add + {3'b000, addr[1:0]};
    return {2'b00, addr[2:0]};
  endfunction

endpackage

// File: rtl/ide_base_regs.sv
module ide_base_regs
  import ide_dec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic [IDXW-1:0]          idx,
  input  logic [AW-1:0]            wdata,
  output logic [NWIN-1:0][AW-1:0]  bases,
  output logic [AW-1:0]            rd_data,
  output logic [AW-1:0]            rd_mask
);

  logic idx_ok;
  assign idx_ok = (int'(idx) < NWIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bases <= '0;
    end else if (ld && idx_ok) begin
      bases[idx] <= {wdata[AW-1:2], 2'b00};
    end
  end

  always_comb begin
    rd_data = '0;
    rd_mask = '0;
    if (idx_ok) begin
      rd_data = bases[idx];
      rd_mask = win_mask(int'(idx));
    end
  end

  // R2: stored bases never carry bits [1:0]
  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_chk
      assert_base_lowbits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bases[g][1:0] == 2'b00);
    end
  endgenerate

  assert_bad_idx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !idx_ok) |=> $stable(bases));

  assert_no_load_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(bases));

endmodule

// File: rtl/ide_win_match.sv
module ide_win_match
  import ide_dec_pkg::*;
#(
  parameter int unsigned LG = 3
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  localparam logic [AW-1:0] LOW_MASK = {AW{1'b1}} >> (AW - LG);

  assign hit = ((addr & ~LOW_MASK) == base);

endmodule

// File: rtl/ide_route.sv
module ide_route
  import ide_dec_pkg::*;
#(
  parameter logic [OFSW-1:0] CTL_OFS = 5'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWIN-1:0]  win_hit,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [AW-1:0]    io_addr,
  input  logic [2:0]       io_size,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             io_hit,
  output logic             ch0_rd,
  output logic             ch0_wr,
  output logic [OFSW-1:0]  ch0_ofs,
  output logic [2:0]       ch0_size,
  output logic [DW-1:0]    ch0_wdata,
  input  logic [DW-1:0]    ch0_rdata,
  output logic             ch1_rd,
  output logic             ch1_wr,
  output logic [OFSW-1:0]  ch1_ofs,
  output logic [2:0]       ch1_size,
  output logic [DW-1:0]    ch1_wdata,
  input  logic [DW-1:0]    ch1_rdata,
  output logic             bm_rd,
  output logic             bm_wr,
  output logic [3:0]       bm_ofs,
  output logic [7:0]       bm_wdata,
  input  logic [7:0]       bm_rdata
);

  // fixed priority, highest first
  localparam int unsigned PRIO [NWIN] = '{0, 2, 1, 3, 4};

  logic [NWIN-1:0] grant;
  logic            taken;
  logic            acc;
  logic            sel_c0, sel_c1, sel_bm;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int k = 0; k < NWIN; k++) begin
      if (!taken && win_hit[PRIO[k]]) begin
        grant[PRIO[k]] = 1'b1;
        taken          = 1'b1;
      end
    end
  end

  assign acc    = io_rd | io_wr;
  assign sel_c0 = grant[WIN_C0_CMD] | grant[WIN_C0_CTL];
  assign sel_c1 = grant[WIN_C1_CMD] | grant[WIN_C1_CTL];
  assign sel_bm = grant[WIN_BM];
  assign io_hit = acc & taken;

  assign ch0_rd    = io_rd & sel_c0;
  assign ch0_wr    = io_wr & sel_c0;
  assign ch0_ofs   = chan_ofs(io_addr, grant[WIN_C0_CTL], CTL_OFS);
  assign ch0_size  = io_size;
  assign ch0_wdata = io_wdata;

  assign ch1_rd    = io_rd & sel_c1;
  assign ch1_wr    = io_wr & sel_c1;
  assign ch1_ofs   = chan_ofs(io_addr, grant[WIN_C1_CTL], CTL_OFS);
  assign ch1_size  = io_size;
  assign ch1_wdata = io_wdata;

  assign bm_rd    = io_rd & sel_bm;
  assign bm_wr    = io_wr & sel_bm;
  assign bm_ofs   = io_addr[3:0];
  assign bm_wdata = io_wdata[7:0];

  always_comb begin
    if (sel_c0)      io_rdata = ch0_rdata;
    else if (sel_c1) io_rdata = ch1_rdata;
    else if (sel_bm) io_rdata = {{(DW-8){1'b0}}, bm_rdata};
    else             io_rdata = '1;
  end

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch0_rd | ch0_wr, ch1_rd | ch1_wr, bm_rd | bm_wr}));

  assert_strobe_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_rd | ch0_wr | ch1_rd | ch1_wr | bm_rd | bm_wr) |-> io_hit);

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> !(ch0_rd | ch0_wr | ch1_rd | ch1_wr | bm_rd | bm_wr));

  assert_miss_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_hit) |-> (io_rdata == '1));

  assert_ctl_ofs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grant[WIN_C0_CTL]) |-> (ch0_ofs >= CTL_OFS && ch0_ofs <= CTL_OFS + 5'd3));

  assert_cmd_ofs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && grant[WIN_C1_CMD]) |-> (ch1_ofs < 5'd8));

  assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_hit[WIN_C0_CMD]) |-> (ch0_rd | ch0_wr));

endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter logic [OFSW-1:0] CTL_OFS = 5'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_ld,
  input  logic [IDXW-1:0]  base_idx,
  input  logic [AW-1:0]    base_wdata,
  output logic [AW-1:0]    base_rdata,
  output logic [AW-1:0]    base_mask,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [AW-1:0]    io_addr,
  input  logic [2:0]       io_size,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             io_hit,
  output logic             ch0_rd,
  output logic             ch0_wr,
  output logic [OFSW-1:0]  ch0_ofs,
  output logic [2:0]       ch0_size,
  output logic [DW-1:0]    ch0_wdata,
  input  logic [DW-1:0]    ch0_rdata,
  output logic             ch1_rd,
  output logic             ch1_wr,
  output logic [OFSW-1:0]  ch1_ofs,
  output logic [2:0]       ch1_size,
  output logic [DW-1:0]    ch1_wdata,
  input  logic [DW-1:0]    ch1_rdata,
  output logic             bm_rd,
  output logic             bm_wr,
  output logic [3:0]       bm_ofs,
  output logic [7:0]       bm_wdata,
  input  logic [7:0]       bm_rdata
);

  logic [NWIN-1:0][AW-1:0] bases;
  logic [NWIN-1:0]         win_hit;

  ide_base_regs u_bases (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (base_ld),
    .idx     (base_idx),
    .wdata   (base_wdata),
    .bases   (bases),
    .rd_data (base_rdata),
    .rd_mask (base_mask)
  );

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      ide_win_match #(.LG(win_lg(w))) u_match (
        .base (bases[w]),
        .addr (io_addr),
        .hit  (win_hit[w])
      );
    end
  endgenerate

  ide_route #(.CTL_OFS(CTL_OFS)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_hit   (win_hit),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_size   (io_size),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_hit    (io_hit),
    .ch0_rd    (ch0_rd),
    .ch0_wr    (ch0_wr),
    .ch0_ofs   (ch0_ofs),
    .ch0_size  (ch0_size),
    .ch0_wdata (ch0_wdata),
    .ch0_rdata (ch0_rdata),
    .ch1_rd    (ch1_rd),
    .ch1_wr    (ch1_wr),
    .ch1_ofs   (ch1_ofs),
    .ch1_size  (ch1_size),
    .ch1_wdata (ch1_wdata),
    .ch1_rdata (ch1_rdata),
    .bm_rd     (bm_rd),
    .bm_wr     (bm_wr),
    .bm_ofs    (bm_ofs),
    .bm_wdata  (bm_wdata),
    .bm_rdata  (bm_rdata)
  );

  // R1: base readback is zero in the first cycle after reset
  assert_reset_zero_R1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (base_rdata == '0));

endmodule

// File: tb/sim_ide_io_decoder.sv
module sim_ide_io_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_ld = 1'b0;
  logic [2:0]  base_idx = '0;
  logic [31:0] base_wdata = '0;
  logic [31:0] base_rdata, base_mask;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_addr = '0;
  logic [2:0]  io_size = 3'd1;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_hit;
  logic        ch0_rd, ch0_wr, ch1_rd, ch1_wr, bm_rd, bm_wr;
  logic [4:0]  ch0_ofs, ch1_ofs;
  logic [2:0]  ch0_size, ch1_size;
  logic [31:0] ch0_wdata, ch1_wdata;
  logic [31:0] ch0_rdata = '0, ch1_rdata = '0;
  logic [3:0]  bm_ofs;
  logic [7:0]  bm_wdata;
  logic [7:0]  bm_rdata = '0;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] mb [5];

  always #10 clk = ~clk;

  ide_io_decoder u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    @(negedge clk);
    base_ld = 1'b1; base_idx = 3'(idx); base_wdata = v;
    @(negedge clk);
    base_ld = 1'b0;
    if (idx < 5) mb[idx] = v & 32'hFFFF_FFFC;
  endtask

  // bench decode: returns the winning window or -1
  function automatic int pick(input logic [31:0] a);
    if ((a >> 3) << 3 == mb[0]) return 0;
    if ((a >> 3) << 3 == mb[2]) return 2;
    if ((a >> 2) << 2 == mb[1]) return 1;
    if ((a >> 2) << 2 == mb[3]) return 3;
    if ((a >> 4) << 4 == mb[4]) return 4;
    return -1;
  endfunction

  function automatic logic [31:0] exp_mask(input int i);
    case (i)
      0, 2:    return 32'hFFFF_FFF9;
      1, 3:    return 32'hFFFF_FFFD;
      4:       return 32'hFFFF_FFF1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic access(input bit rd, input bit wr, input logic [31:0] a,
                        input string req);
    int w;
    logic [5:0]  es, as;
    logic [31:0] er;
    logic [4:0]  eo;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a;
    io_size  = (($urandom % 3) == 0) ? 3'd4 : 3'(1 << ($urandom % 2));
    io_wdata = $urandom;
    ch0_rdata = $urandom; ch1_rdata = $urandom; bm_rdata = 8'($urandom);
    #5;
    w  = pick(a);
    es = '0;
    case (w)
      0, 1: es = {rd, wr, 4'b0};
      2, 3: es = {2'b0, rd, wr, 2'b0};
      4:    es = {4'b0, rd, wr};
      default: es = '0;
    endcase
    as = {ch0_rd, ch0_wr, ch1_rd, ch1_wr, bm_rd, bm_wr};
    chk(io_hit == ((rd | wr) && w >= 0), req, "hit", 32'(io_hit), 32'((rd | wr) && w >= 0));
    chk(as == es, req, "strobes", 32'(as), 32'(es));
    if (rd) begin
      er = (w == 0 || w == 1) ? ch0_rdata : (w == 2 || w == 3) ? ch1_rdata :
           (w == 4) ? {24'h0, bm_rdata} : 32'hFFFF_FFFF;
      chk(io_rdata == er, req, "rdata", io_rdata, er);
    end
    if (w == 0 || w == 2) eo = 5'(a % 8);
    else eo = 5'(20 + a % 4);
    if (w == 0 || w == 1) begin
      chk(ch0_ofs == eo && ch0_size == io_size && ch0_wdata == io_wdata,
          req, "ch0 ofs", 32'(ch0_ofs), 32'(eo));
    end else if (w == 2 || w == 3) begin
      chk(ch1_ofs == eo && ch1_size == io_size && ch1_wdata == io_wdata,
          req, "ch1 ofs", 32'(ch1_ofs), 32'(eo));
    end else if (w == 4) begin
      chk(bm_ofs == a[3:0] && bm_wdata == io_wdata[7:0], "R6", "bm ofs/wdata",
          {bm_wdata, 20'h0, bm_ofs}, {io_wdata[7:0], 20'h0, a[3:0]});
    end
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] lo [5];
    int          span [5];
    void'($urandom(32'd7411));
    for (int i = 0; i < 5; i++) mb[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 masks
    for (int i = 0; i < 8; i++) begin
      base_idx = 3'(i); #1;
      chk(base_rdata == 32'h0, "R1", "base after reset", base_rdata, 32'h0);
      chk(base_mask == exp_mask(i), "R3", "sizing mask", base_mask, exp_mask(i));
    end

    // R2 loads with low bits forced clear
    load(0, 32'h0000_01F0);
    load(1, 32'h0000_03F7);
    load(2, 32'h0000_0170);
    load(3, 32'h0000_0376);
    load(4, 32'h0000_C003);
    load(5, 32'hDEAD_BEEF);
    load(7, 32'h1234_5678);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = (i < 5) ? mb[i] : 32'h0;
      base_idx = 3'(i); #1;
      chk(base_rdata == e, "R2", "base readback", base_rdata, e);
    end

    // boundaries: first, last, one below, one above
    lo = '{32'h1F0, 32'h3F4, 32'h170, 32'h374, 32'hC000};
    span = '{8, 4, 8, 4, 16};
    for (int i = 0; i < 5; i++) begin
      string r;
      r = (i == 4) ? "R6" : (i % 2 == 0) ? "R4" : "R5";
      access(1, 0, lo[i], r);
      access(1, 0, lo[i] + 32'(span[i]) - 1, r);
      access(0, 1, lo[i] + 32'(span[i]) - 1, r);
      access(1, 0, lo[i] - 1, "R8");
      access(1, 0, lo[i] + 32'(span[i]), "R8");
      access(0, 1, lo[i] + 32'(span[i]), "R8");
    end
    access(0, 0, 32'h1F2, "R9");
    access(1, 0, 32'h0000_0000, "R8");

    // R7 overlaps
    load(2, 32'h1F0);
    access(1, 0, 32'h1F3, "R7");
    load(1, 32'h174);
    load(2, 32'h170);
    access(1, 0, 32'h176, "R7");
    load(3, 32'h174);
    load(2, 32'h900);
    access(0, 1, 32'h175, "R7");
    load(4, 32'h370);
    load(3, 32'h374);
    load(1, 32'h800);
    access(1, 0, 32'h377, "R7");
    access(1, 0, 32'h373, "R7");

    // random: bases drawn from a small clustered pool to force overlaps
    for (int n = 0; n < 600; n++) begin
      int i, t;
      if (n % 40 == 0) begin
        for (int k = 0; k < 5; k++)
          load(k, 32'h400 + 32'(($urandom % 8) * 4) + 32'($urandom % 4));
      end
      i = $urandom % 5;
      t = $urandom % 4;
      access(t == 0 || t == 2, t == 1 || t == 2 ? (t == 1) : 1'b0,
             mb[i] + 32'($urandom % 24) - 32'd4, "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule